// File: doc/BRIEF.md
# Complementary Pulse Train Generator

This block produces a finite burst of pulses on a pair of complementary drive outputs, an anode drive and a cathode drive. At rest the anode drive is high and the cathode drive is low. During a pulse both outputs invert together. The block is set up with an idle time and a pulse width, each in microseconds, and a pulse count. A one-cycle start strobe loads these settings. Time is counted in ticks of the block clock, with a fixed number of ticks per microsecond (16 by default).

Each period opens with the idle phase, in which the outputs sit at rest. The pulse phase follows, with both outputs inverted. One period is idle plus width. After the requested number of periods the block returns to rest and drops its busy flag. A start with illegal settings is refused: the status flag goes low and nothing else changes. A legal start aborts any burst in progress and begins the new one at once.

The controller has three states. STOP is at rest, not busy. IDLE is at rest, busy. PULSE has the outputs inverted, busy. The transitions are:
- start-accept: any state goes to IDLE.
- idle-done: IDLE goes to PULSE.
- period-done-more: PULSE goes to IDLE while pulses remain.
- period-done-last: PULSE goes to STOP after the final pulse.

Top module: `pulse_burst_gen`

## Requirements
- R1: A synchronous active-high reset puts the block in STOP, with anode_drv=1, cathode_drv=0, busy=0 and cfg_ok=0.
- R2: A start is accepted only if idle_us and width_us both lie in MIN_TIME..MAX_TIME (2..32767 by default) and pulse_count is not zero. Any other start is refused.
- R3: cfg_ok is updated on the clock edge that samples start. It becomes 1 for an accepted start and 0 for a refused one, and holds that value until the next start or reset.
- R4: Whenever busy is 0, anode_drv=1 and cathode_drv=0.
- R5: Call the accepting edge m=0 and let I = idle_us*TICKS_PER_US. After edges m=0..I-1 the outputs are at rest and busy=1.
- R6: Let P = (idle_us+width_us)*TICKS_PER_US. Within each period, after edges with (m mod P) >= I, anode_drv=0 and cathode_drv=1. Both outputs change on the same edge.
- R7: busy stays 1 for exactly pulse_count*P edges after the accepting edge and then falls, so exactly pulse_count pulses are produced. busy falls only at the end of a pulse phase.
- R8: An accepted start while busy abandons the current burst. On that edge the outputs return to rest and the new burst begins at m=0 with the new settings.
- R9: A refused start while busy leaves the running burst unchanged: its output waveform and busy timing continue as if no start had occurred.
- R10: The tick counter is wide enough for 2*MAX_TIME*TICKS_PER_US (20 bits by default) and never reaches the period length while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, TICKS_PER_US ticks per microsecond |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle start request; samples the settings |
| idle_us | input | TIME_W | Idle phase length in microseconds |
| width_us | input | TIME_W | Pulse phase length in microseconds |
| pulse_count | input | CNT_W | Number of pulses in the burst |
| cfg_ok | output | 1 | 1 if the last start was accepted, 0 if refused |
| busy | output | 1 | High while a burst is running |
| anode_drv | output | 1 | Anode drive, rests high |
| cathode_drv | output | 1 | Cathode drive, rests low |

## Verification
The assertions assume that the settings are valid only at the edge where start is sampled. They assume nothing about the settings at other times, since those are ignored. The bench uses a small configuration: one tick per microsecond, a legal range of 2..5, and a 3-bit count. It sweeps every legal idle, width and count combination, plus several illegal values on each side of the range, with start held for exactly one cycle. Restart and refusal during a running burst are driven on chosen edges, and the expected waveform is recomputed from the arithmetic timeline.

// File: rtl/pbg_pkg.sv
`timescale 1ns/1ps
package pbg_pkg;
    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_PULSE = 2'd2
    } burst_state_t;
endpackage

// File: rtl/pbg_param_check.sv
`timescale 1ns/1ps
module pbg_param_check #(
    parameter int TIME_W   = 16,
    parameter int CNT_W    = 32,
    parameter int MIN_TIME = 2,
    parameter int MAX_TIME = 32767
) (
    input  logic [TIME_W-1:0] idle_us,
    input  logic [TIME_W-1:0] width_us,
    input  logic [CNT_W-1:0]  pulse_count,
    output logic              legal
);
    localparam logic [TIME_W-1:0] LO = TIME_W'(MIN_TIME);
    localparam logic [TIME_W-1:0] HI = TIME_W'(MAX_TIME);

    always_comb begin
        legal = (idle_us  >= LO) && (idle_us  <= HI) &&
                (width_us >= LO) && (width_us <= HI) &&
                (pulse_count != '0);
    end
endmodule

// File: rtl/pbg_tick_timer.sv
`timescale 1ns/1ps
module pbg_tick_timer #(
    parameter int TCNT_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              run,
    input  logic [TCNT_W-1:0] idle_ticks,
    input  logic [TCNT_W-1:0] period_ticks,
    output logic              idle_end,
    output logic              period_end
);
    logic [TCNT_W-1:0] tcnt;
    logic [TCNT_W-1:0] idle_q;
    logic [TCNT_W-1:0] period_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt     <= '0;
            idle_q   <= '0;
            period_q <= '0;
        end else if (load) begin
            tcnt     <= '0;
            idle_q   <= idle_ticks;
            period_q <= period_ticks;
        end else if (run && !period_end) begin
            tcnt <= tcnt + TCNT_W'(1);
        end else begin
            tcnt <= '0;
        end
    end

    always_comb begin
        idle_end   = (tcnt == idle_q   - TCNT_W'(1));
        period_end = (tcnt == period_q - TCNT_W'(1));
    end

    // R10: counter stays inside the latched period while running
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        run |-> (tcnt < period_q));
endmodule

// File: rtl/pbg_pulse_counter.sv
`timescale 1ns/1ps
module pbg_pulse_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] count_in,
    input  logic             step,
    input  logic             run,
    output logic             last
);
    logic [CNT_W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (rst)
            remaining <= '0;
        else if (load)
            remaining <= count_in;
        else if (step)
            remaining <= remaining - CNT_W'(1);
    end

    always_comb last = (remaining == CNT_W'(1));

    // R7: a running burst always has at least one pulse left
    assert_count_live_R7: assert property (@(posedge clk) disable iff (rst)
        run |-> (remaining != '0));
endmodule

// File: rtl/pulse_burst_gen.sv
`timescale 1ns/1ps
module pulse_burst_gen
    import pbg_pkg::*;
#(
    parameter int TICKS_PER_US = 16,
    parameter int TIME_W       = 16,
    parameter int CNT_W        = 32,
    parameter int MIN_TIME     = 2,
    parameter int MAX_TIME     = 32767
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [TIME_W-1:0] idle_us,
    input  logic [TIME_W-1:0] width_us,
    input  logic [CNT_W-1:0]  pulse_count,
    output logic              cfg_ok,
    output logic              busy,
    output logic              anode_drv,
    output logic              cathode_drv
);
    localparam int TCNT_W = $clog2(2 * MAX_TIME * TICKS_PER_US + 1);

    burst_state_t state_q, state_d;
    logic legal, accept, idle_end, period_end, last, step, running;
    logic [TCNT_W-1:0] idle_ticks, period_ticks;

    pbg_param_check #(
        .TIME_W(TIME_W), .CNT_W(CNT_W), .MIN_TIME(MIN_TIME), .MAX_TIME(MAX_TIME)
    ) u_check (
        .idle_us(idle_us), .width_us(width_us), .pulse_count(pulse_count), .legal(legal)
    );

    always_comb begin
        accept       = start && legal;
        idle_ticks   = TCNT_W'(idle_us) * TCNT_W'(TICKS_PER_US);
        period_ticks = (TCNT_W'(idle_us) + TCNT_W'(width_us)) * TCNT_W'(TICKS_PER_US);
        running      = (state_q != ST_STOP);
        step         = (state_q == ST_PULSE) && period_end && !accept;
    end

    pbg_tick_timer #(.TCNT_W(TCNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(accept), .run(running),
        .idle_ticks(idle_ticks), .period_ticks(period_ticks),
        .idle_end(idle_end), .period_end(period_end)
    );

    pbg_pulse_counter #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst(rst), .load(accept), .count_in(pulse_count),
        .step(step), .run(running), .last(last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (accept) begin
            state_d = ST_IDLE;                  // start-accept
        end else begin
            unique case (state_q)
                ST_STOP:  state_d = ST_STOP;
                ST_IDLE:  if (idle_end) state_d = ST_PULSE;      // idle-done
                ST_PULSE: if (period_end)
                              state_d = last ? ST_STOP : ST_IDLE; // period-done
                default:  state_d = ST_STOP;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_STOP;
        else     state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            anode_drv   <= 1'b1;
            cathode_drv <= 1'b0;
            busy        <= 1'b0;
            cfg_ok      <= 1'b0;
        end else begin
            anode_drv   <= (state_d != ST_PULSE);
            cathode_drv <= (state_d == ST_PULSE);
            busy        <= (state_d != ST_STOP);
            if (start) cfg_ok <= legal;
        end
    end

    // R4: outputs rest whenever not busy
    assert_rest_R4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (anode_drv && !cathode_drv));

    // R8: accepted start gives a fresh burst at rest
    assert_accept_restarts_R8: assert property (@(posedge clk) disable iff (rst)
        (start && legal) |=> (busy && cfg_ok && anode_drv && !cathode_drv));

    // R9: refused start leaves busy untouched
    assert_reject_keeps_R9: assert property (@(posedge clk) disable iff (rst)
        (start && !legal) |=> (!cfg_ok && busy == $past(busy)));

    // R7: the burst ends only after a pulse phase
    assert_stop_after_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(start)) |-> $past(cathode_drv));
endmodule

// File: tb/pulse_burst_gen_test.sv
`timescale 1ns/1ps
module pulse_burst_gen_test;
    localparam int TPU = 1;
    localparam int TW  = 4;
    localparam int CW  = 3;
    localparam int LO  = 2;
    localparam int HI  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [TW-1:0] idle_us = '0;
    logic [TW-1:0] width_us = '0;
    logic [CW-1:0] pulse_count = '0;
    logic cfg_ok, busy, anode_drv, cathode_drv;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pulse_burst_gen #(
        .TICKS_PER_US(TPU), .TIME_W(TW), .CNT_W(CW), .MIN_TIME(LO), .MAX_TIME(HI)
    ) uut (
        .clk(clk), .rst(rst), .start(start), .idle_us(idle_us), .width_us(width_us),
        .pulse_count(pulse_count), .cfg_ok(cfg_ok), .busy(busy),
        .anode_drv(anode_drv), .cathode_drv(cathode_drv)
    );

    task automatic check_bits(string req, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {busy,anode,cathode} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic check_ok(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: cfg_ok actual=%b expected=%b", req, act, exp);
        end
    endtask

    // expected waveform point m edges after the accepting edge
    task automatic expect_point(int iu, int wu, int n, int m);
        int it = iu * TPU;
        int p  = (iu + wu) * TPU;
        logic b = (m < n * p);
        logic act = b && ((m % p) >= it);
        string req;
        if (!b)            req = "R7/R4";
        else if (m % p < it) req = "R5";
        else               req = "R6";
        check_bits(req, {busy, anode_drv, cathode_drv}, {b, ~act, act});
    endtask

    // drive a one-cycle start; returns at the m=0 sample point
    task automatic pulse_start(int iu, int wu, int n);
        @(negedge clk);
        idle_us = TW'(iu); width_us = TW'(wu); pulse_count = CW'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic full_burst(int iu, int wu, int n);
        pulse_start(iu, wu, n);
        check_ok("R3", cfg_ok, 1'b1);
        for (int m = 0; m <= n * (iu + wu) * TPU + 2; m++) begin
            expect_point(iu, wu, n, m);
            @(negedge clk);
        end
    endtask

    task automatic refused(int iu, int wu, int n);
        pulse_start(iu, wu, n);
        check_ok("R2", cfg_ok, 1'b0);
        for (int k = 0; k < 4; k++) begin
            check_bits("R2", {busy, anode_drv, cathode_drv}, 3'b010);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check_bits("R1", {busy, anode_drv, cathode_drv}, 3'b010);
        check_ok("R1", cfg_ok, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check_bits("R1", {busy, anode_drv, cathode_drv}, 3'b010);

        // R5 R6 R7: every legal combination
        for (int i = LO; i <= HI; i++)
            for (int w = LO; w <= HI; w++)
                for (int n = 1; n < (1 << CW); n++)
                    full_burst(i, w, n);

        // R2 R3: refused settings
        refused(1, 3, 2);
        refused(0, 3, 2);
        refused(6, 3, 2);
        refused(15, 3, 2);
        refused(3, 1, 2);
        refused(3, 6, 2);
        refused(3, 0, 2);
        refused(3, 3, 0);
        full_burst(LO, HI, 1);   // accepted again after refusals (R3)

        // R8: restart while busy
        pulse_start(3, 3, 4);
        for (int m = 0; m < 5; m++) begin
            expect_point(3, 3, 4, m);
            if (m < 4) @(negedge clk);
        end
        pulse_start(2, 4, 2);
        check_ok("R8", cfg_ok, 1'b1);
        for (int m = 0; m <= 14; m++) begin
            expect_point(2, 4, 2, m);
            @(negedge clk);
        end

        // R9: refused start mid-burst leaves the burst running
        pulse_start(4, 2, 3);
        for (int m = 0; m <= 20; m++) begin
            expect_point(4, 2, 3, m);
            if (m == 7) begin
                idle_us = TW'(1); width_us = TW'(9); pulse_count = '0;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            if (m == 7) check_ok("R9", cfg_ok, 1'b0);
        end
        start = 1'b0;

        // R1: reset in the middle of a burst
        pulse_start(5, 5, 7);
        repeat (7) @(negedge clk);
        check_bits("R6", {busy, anode_drv, cathode_drv}, 3'b101);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_bits("R1", {busy, anode_drv, cathode_drv}, 3'b010);
        check_ok("R1", cfg_ok, 1'b0);
        repeat (3) @(negedge clk);
        check_bits("R4", {busy, anode_drv, cathode_drv}, 3'b010);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule